// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Pending-Request Stacking

This block keeps DRAM contents alive by issuing refresh cycles at a programmable interval. A down-counting interval timer raises a refresh request each time its period elapses. Each request is carried out as a CAS-before-RAS cycle on the active-low strobes, so no row address is involved. While the normal access path is busy, requests cannot be served. They accumulate in a small pending counter that saturates at seven. Once the bus is free, the stacked requests are drained back to back, separated only by the precharge time.

A configuration write loads the interval and the enable bit. Writing the enable bit restarts the timer from its full period. Clearing the enable bit stops new requests, but requests already pending are still served. The external reset input does not clear the scheduler. While it is high, the scheduler keeps issuing refreshes and no longer waits for the access path's busy flag, because that path is held in reset. Only the separate power-on reset clears the block.

Top module: `dram_refresh_sched`

## Requirements
- R1: After power-on reset (porRstN low), rasN and casN are high, refBusy is low and refresh is disabled; no casN fall occurs until a configuration write sets the enable.
- R2: A write (cfgWe high at a rising edge k) loads cfgPeriod P (P >= 2) and cfgEnable. With the enable set, the timer restarts and a request is registered at edge k+P and then every P edges. When the bus is free, casN first goes low at edge k+P+2, and in steady state consecutive casN falls are P cycles apart.
- R3: In each refresh cycle, casN falls exactly CAS_LEAD cycles before rasN falls, and rasN is never low while casN is high.
- R4: rasN stays low for exactly RAS_WIDTH cycles. casN and rasN rise on the same edge, and both then stay high for at least PRECHARGE cycles before the next casN fall.
- R5: refBusy is high in every cycle in which casN or rasN is low.
- R6: A refresh starts only if accBusy was low, or extRst high, at the deciding edge. No refresh starts while accBusy is high and extRst low. Raising accBusy does not cut short a refresh already running.
- R7: Pending requests saturate at seven, and further ticks are dropped. After N ticks while blocked, exactly min(N,7) refresh cycles are served once the bus frees. A tick and a completion in the same cycle leave the count unchanged.
- R8: Stacked requests are served back to back. With the bus free, consecutive casN falls in a drain are CAS_LEAD+RAS_WIDTH+PRECHARGE cycles apart.
- R9: Writing cfgEnable=0 stops new requests from being generated, while requests already pending are still served.
- R10: extRst clears neither the timer, the period, the enable nor the pending count. Refreshes continue every P cycles while it is high, even with accBusy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, clears all state |
| extRst | input | 1 | External system reset; refresh keeps running and accBusy is ignored while high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPeriod | input | PERIOD_W | Refresh interval in clock cycles |
| cfgEnable | input | 1 | Refresh enable written with cfgWe |
| accBusy | input | 1 | Normal access path is using the memory |
| refBusy | output | 1 | Refresh owns the memory bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |

## Verification
The bench builds the block with an 8-bit period, a CAS lead of 2, a RAS width of 3 and a precharge of 2, so one refresh cycle spans 7 clocks. With these values, exact first-refresh timing and steady intervals can be swept over periods 8 to 13. A period of 3 with the bus held busy puts every tick count from 0 to 9 in reach, covering the saturation point at seven and the drop beyond it. The same short period exposes the back-to-back spacing during the drain.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    RS_IDLE,
    RS_LEAD,
    RS_RAS,
    RS_PRE
  } refState_e;

  typedef struct packed {
    logic casOn;
    logic rasOn;
    logic done;
  } refStrobe_t;
endpackage

// File: rtl/refresh_ctl.sv
module refresh_ctl
  import refresh_pkg::*;
#(
  parameter int CAS_LEAD  = 2,
  parameter int RAS_WIDTH = 3,
  parameter int PRECHARGE = 2
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       pendAny,
  input  logic       pendMulti,
  input  logic       grant,
  output refStrobe_t strobe,
  output logic       refBusy
);
  localparam int MAX_A = (CAS_LEAD > RAS_WIDTH) ? CAS_LEAD : RAS_WIDTH;
  localparam int MAX_PH = (MAX_A > PRECHARGE) ? MAX_A : PRECHARGE;
  localparam int CNT_W = (MAX_PH < 2) ? 1 : $clog2(MAX_PH);
  localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(CAS_LEAD - 1);
  localparam logic [CNT_W-1:0] RAS_LD  = CNT_W'(RAS_WIDTH - 1);
  localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(PRECHARGE - 1);

  refState_e state, stateNxt;
  logic [CNT_W-1:0] phCnt, phCntNxt;
  logic phEnd;

  assign phEnd = (phCnt == '0);

  always_comb begin
    stateNxt = state;
    phCntNxt = phEnd ? phCnt : phCnt - 1'b1;
    strobe.done = 1'b0;
    unique case (state)
      RS_IDLE: if (pendAny && grant) begin
        stateNxt = RS_LEAD;
        phCntNxt = LEAD_LD;
      end
      RS_LEAD: if (phEnd) begin
        stateNxt = RS_RAS;
        phCntNxt = RAS_LD;
      end
      RS_RAS: if (phEnd) begin
        stateNxt = RS_PRE;
        phCntNxt = PRE_LD;
      end
      RS_PRE: if (phEnd) begin
        strobe.done = 1'b1;
        if (pendMulti && grant) begin
          stateNxt = RS_LEAD;
          phCntNxt = LEAD_LD;
        end else begin
          stateNxt = RS_IDLE;
        end
      end
      default: stateNxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state <= RS_IDLE;
      phCnt <= '0;
    end else begin
      state <= stateNxt;
      phCnt <= phCntNxt;
    end
  end

  assign strobe.casOn = (state == RS_LEAD) || (state == RS_RAS);
  assign strobe.rasOn = (state == RS_RAS);
  assign refBusy      = (state != RS_IDLE);

  // R6: entry into the CAS lead phase only follows a granted cycle
  a_r6_start_granted: assert property (@(posedge clk) disable iff (!porRstN)
    (state == RS_LEAD && $past(state) != RS_LEAD) |-> $past(grant));

  // R7: a completion only happens with work outstanding
  a_r7_done_needs_pend: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.done |-> pendAny);
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int PERIOD_W  = 8,
  parameter int STACK_MAX = 7
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                cfgWe,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                cfgEnable,
  input  refStrobe_t          strobe,
  output logic                pendAny,
  output logic                pendMulti,
  output logic                rasN,
  output logic                casN
);
  localparam int PEND_W = $clog2(STACK_MAX + 1);
  localparam logic [PEND_W-1:0] PEND_CAP = PEND_W'(STACK_MAX);

  logic [PERIOD_W-1:0] periodReg, tmr;
  logic                enReg, tick;
  logic [PEND_W-1:0]   pend;

  assign tick = enReg && !cfgWe && (tmr <= PERIOD_W'(1));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      periodReg <= '0;
      enReg     <= 1'b0;
      tmr       <= '0;
    end else if (cfgWe) begin
      periodReg <= cfgPeriod;
      enReg     <= cfgEnable;
      tmr       <= cfgPeriod;
    end else if (enReg) begin
      tmr <= tick ? periodReg : tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pend <= '0;
    end else begin
      unique case ({tick, strobe.done})
        2'b10: if (pend != PEND_CAP) pend <= pend + 1'b1;
        2'b01: pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign pendAny   = (pend != '0);
  assign pendMulti = (pend > PEND_W'(1));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
    end else begin
      rasN <= !strobe.rasOn;
      casN <= !strobe.casOn;
    end
  end

  // R7: a tick arriving at the cap is dropped
  a_r7_hold_at_cap: assert property (@(posedge clk) disable iff (!porRstN)
    (pend == PEND_CAP && tick && !strobe.done) |=> pend == PEND_CAP);

  // R9: with the timer disabled, the pending count can only shrink
  a_r9_no_growth_disabled: assert property (@(posedge clk) disable iff (!porRstN)
    (!enReg && !cfgWe) |=> pend <= $past(pend));

  // R9: a disabled timer holds its value
  a_r9_timer_frozen: assert property (@(posedge clk) disable iff (!porRstN)
    (!enReg && !cfgWe) |=> $stable(tmr));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refresh_pkg::*;
#(
  parameter int PERIOD_W  = 8,
  parameter int STACK_MAX = 7,
  parameter int CAS_LEAD  = 2,
  parameter int RAS_WIDTH = 3,
  parameter int PRECHARGE = 2
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                extRst,
  input  logic                cfgWe,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                cfgEnable,
  input  logic                accBusy,
  output logic                refBusy,
  output logic                rasN,
  output logic                casN
);
  refStrobe_t strobe;
  logic pendAny, pendMulti, grant;

  assign grant = !accBusy || extRst;

  refresh_ctl #(
    .CAS_LEAD (CAS_LEAD),
    .RAS_WIDTH(RAS_WIDTH),
    .PRECHARGE(PRECHARGE)
  ) u_ctl (
    .clk      (clk),
    .porRstN  (porRstN),
    .pendAny  (pendAny),
    .pendMulti(pendMulti),
    .grant    (grant),
    .strobe   (strobe),
    .refBusy  (refBusy)
  );

  refresh_dp #(
    .PERIOD_W (PERIOD_W),
    .STACK_MAX(STACK_MAX)
  ) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .cfgWe    (cfgWe),
    .cfgPeriod(cfgPeriod),
    .cfgEnable(cfgEnable),
    .strobe   (strobe),
    .pendAny  (pendAny),
    .pendMulti(pendMulti),
    .rasN     (rasN),
    .casN     (casN)
  );

  // R3: the row strobe falls only while the column strobe is already low
  a_r3_cas_first: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(rasN) |-> !$past(casN));

  // R4: both strobes are released on the same edge
  a_r4_joint_release: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(rasN) |-> $rose(casN));

  // R5: the bus is held whenever a strobe is active
  a_r5_busy_cover: assert property (@(posedge clk) disable iff (!porRstN)
    (!casN || !rasN) |-> refBusy);

  // R6: a column strobe fall traces back to a granted deciding edge
  a_r6_cas_gated: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(casN) |-> (!$past(accBusy, 2) || $past(extRst, 2)));
endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int CL = 2;
  localparam int RW = 3;
  localparam int PR = 2;
  localparam int TCYC = CL + RW + PR;
  localparam int CAP = 7;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic extRst = 1'b0;
  logic cfgWe = 1'b0;
  logic [PW-1:0] cfgPeriod = '0;
  logic cfgEnable = 1'b0;
  logic accBusy = 1'b0;
  logic refBusy, rasN, casN;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_sched #(
    .PERIOD_W(PW), .STACK_MAX(CAP), .CAS_LEAD(CL), .RAS_WIDTH(RW), .PRECHARGE(PR)
  ) u_dram_refresh_sched (
    .clk(clk), .porRstN(porRstN), .extRst(extRst), .cfgWe(cfgWe),
    .cfgPeriod(cfgPeriod), .cfgEnable(cfgEnable), .accBusy(accBusy),
    .refBusy(refBusy), .rasN(rasN), .casN(casN)
  );

  // strobe monitor, sampled at the falling edge
  int cyc = 0, casFalls = 0, lastFall = 0, lastCasRise = 0, rasFall = 0;
  int orderBad = 0, busyBad = 0, leadBad = 0, widthBad = 0, riseBad = 0, gapBad = 0;
  logic prevCas = 1'b1, prevRas = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (porRstN) begin
      if (!rasN && casN) orderBad++;
      if ((!casN || !rasN) && !refBusy) busyBad++;
      if (prevCas && !casN) begin
        if (casFalls > 0 && (cyc - lastCasRise) < PR) gapBad++;
        casFalls++;
        lastFall = cyc;
      end
      if (!prevCas && casN) begin
        lastCasRise = cyc;
        if (!(rasN && !prevRas)) riseBad++;
      end
      if (prevRas && !rasN) begin
        rasFall = cyc;
        if (cyc - lastFall != CL) leadBad++;
      end
      if (!prevRas && rasN && (cyc - rasFall != RW)) widthBad++;
    end
    prevCas = casN;
    prevRas = rasN;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitNeg();
    @(negedge clk);
    #1;
  endtask

  task automatic cfgWrite(input int p, input bit en);
    waitNeg();
    cfgWe = 1'b1;
    cfgPeriod = PW'(p);
    cfgEnable = en;
    waitNeg();
    cfgWe = 1'b0;
  endtask

  task automatic waitFall(input string tag);
    int base = casFalls;
    int n = 0;
    while (casFalls == base && n < 500) begin
      waitNeg();
      n++;
    end
    check(casFalls != base, tag, n, 500);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int f0, base, expN;
    // R1: reset state
    repeat (3) waitNeg();
    check(rasN && casN && !refBusy, "R1 reset strobes", {rasN, casN, refBusy}, 3'b110);
    porRstN = 1'b1;
    base = casFalls;
    repeat (50) waitNeg();
    check(casFalls == base, "R1 no refresh before enable", casFalls - base, 0);

    // R2: first-request timing and steady interval over a period sweep
    for (int p = 8; p <= 13; p++) begin
      cfgWrite(p, 1'b1);
      repeat (p + 1) waitNeg();
      check(casN == 1'b1, "R2 casN high at edge k+P+1", casN, 1);
      waitNeg();
      check(casN == 1'b0, "R2 casN low at edge k+P+2", casN, 0);
      f0 = lastFall;
      for (int i = 0; i < 3; i++) begin
        waitFall("R2 next refresh");
        check(lastFall - f0 == p, "R2 interval", lastFall - f0, p);
        f0 = lastFall;
      end
      cfgWrite(p, 1'b0);
      repeat (40) waitNeg();
    end

    // R7 R8 R9: stacking sweep with the bus held busy
    for (int n = 0; n <= 9; n++) begin
      accBusy = 1'b1;
      base = casFalls;
      cfgWrite(3, 1'b1);
      repeat (3 * n) waitNeg();
      cfgWrite(3, 1'b0);
      repeat (5) waitNeg();
      check(casFalls == base, "R6 blocked while accBusy", casFalls - base, 0);
      expN = (n < CAP) ? n : CAP;
      accBusy = 1'b0;
      if (n > 0) waitFall("R7 drain start");
      f0 = lastFall;
      repeat (70) waitNeg();
      check(casFalls - base == expN, "R7 R9 served count", casFalls - base, expN);
      if (expN >= 2)
        check(lastFall - f0 == (expN - 1) * TCYC, "R8 back-to-back span",
              lastFall - f0, (expN - 1) * TCYC);
    end

    // R10: external reset keeps refresh running and overrides accBusy
    accBusy = 1'b1;
    extRst = 1'b1;
    cfgWrite(10, 1'b1);
    waitFall("R10 refresh under extRst");
    f0 = lastFall;
    for (int i = 0; i < 3; i++) begin
      waitFall("R10 next refresh");
      check(lastFall - f0 == 10, "R10 interval under extRst", lastFall - f0, 10);
      f0 = lastFall;
    end
    extRst = 1'b0;
    base = casFalls;
    repeat (30) waitNeg();
    check(casFalls == base, "R6 blocked after extRst release", casFalls - base, 0);
    accBusy = 1'b0;
    repeat (60) waitNeg();
    waitFall("R10 resumed");
    f0 = lastFall;
    waitFall("R10 resumed next");
    check(lastFall - f0 == 10, "R10 period kept", lastFall - f0, 10);
    cfgWrite(10, 1'b0);
    repeat (60) waitNeg();

    // R6: raising accBusy mid-cycle does not cut the refresh short
    cfgWrite(20, 1'b1);
    waitFall("R6 refresh before busy");
    accBusy = 1'b1;
    repeat (10) waitNeg();
    check(rasN && casN, "R6 refresh completes under busy", {rasN, casN}, 2'b11);
    base = casFalls;
    repeat (60) waitNeg();
    check(casFalls == base, "R6 no start while busy", casFalls - base, 0);
    cfgWrite(20, 1'b0);
    accBusy = 1'b0;
    repeat (60) waitNeg();

    check(orderBad == 0, "R3 rasN low with casN high", orderBad, 0);
    check(leadBad == 0, "R3 CAS lead length", leadBad, 0);
    check(widthBad == 0, "R4 RAS width", widthBad, 0);
    check(riseBad == 0, "R4 joint release", riseBad, 0);
    check(gapBad == 0, "R4 precharge gap", gapBad, 0);
    check(busyBad == 0, "R5 refBusy cover", busyBad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule